// File: doc/BRIEF.md
# Register File with Aliased Special Addresses

This block is a 160-word by 32-bit register file with two read ports and one write port. It sits beside a datapath that runs on a two-phase clock. Here that clock is a single clock plus a phase flag, `ph_b`. On a clock edge where `ph_b` is high, the block takes the three register addresses from a control word and latches the reject input. On the next edge, where `ph_b` is low, it does both operand reads and the single write, using those latched addresses.

Part of the address space does not map to plain storage:
- Address 128 is a sink: writes to it are dropped.
- Address 129 sends the written word onto an output bus instead of into storage.
- Address 130 holds the memory address register.
- Address 131 holds the field register. A write there also refreshes a separate field copy that the operand path uses.
- Address 132 always reads as zero.

When reject is latched, the write address is replaced by 130, so the faulting address lands in the memory address register. Any address of 160 or higher raises an error flag.

Top module: `rf_special`

## Requirements
- R1: Synchronous active-high reset produces the following state:
  - `rd_a`, `rd_b`, `bus_out`, `field_copy` are 0.
  - `bus_valid` and `addr_err` are 0.
  - The latched write address is 128, so a phase-A edge before any phase-B capture stores nothing and does not assert `bus_valid`.
  - The latched read addresses are 132.
- R2: Capture and action happen on different edges:
  - On an edge with `ph_b`=1, read address A is taken from `ctrl_word[7:0]`, read address B from `ctrl_word[15:8]`, and the write address from `ctrl_word[23:16]`. `reject_in` is latched on the same edge.
  - All outputs change only on edges with `ph_b`=0.
  - `reject_in` and `ctrl_word` are ignored on edges with `ph_b`=0.
- R3: On a phase-A edge, `wr_data` is stored at the latched write address if that address is 0–127 or 130–159. Later reads of that address return the stored word. A read on the same edge returns the contents from before the write.
- R4: Reading address 132 returns zero whatever was written to it.
- R5: A write to address 128 changes no storage location and does not touch the bus. Reads of 128 return zero.
- R6: A write to address 129 loads `wr_data` into `bus_out` and raises `bus_valid` until the next phase-A edge. Nothing is stored, reads of 129 return zero, and `bus_out` keeps its value otherwise.
- R7: If `reject_in` was 1 at the phase-B capture, the write goes to address 130 whatever the write field holds, and `field_copy` is not updated.
- R8: A write to address 131 without reject stores the word and also loads it into `field_copy`. `field_copy` changes on no other write.
- R9: If read address A, read address B or the write address is 160 or above, `addr_err` is 1 after that phase-A edge. An illegal write stores nothing, and an illegal read returns zero.
- R10: The two read ports are independent: A and B may read different or equal addresses on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_b | input | 1 | Phase flag: 1 = capture edge, 0 = read/write edge |
| ctrl_word | input | 32 | Control word carrying the three addresses |
| reject_in | input | 1 | Reject, sampled on capture edges |
| wr_data | input | 32 | Write-port data, used on read/write edges |
| rd_a | output | 32 | Read port A data |
| rd_b | output | 32 | Read port B data |
| bus_out | output | 32 | Output bus word written via address 129 |
| bus_valid | output | 1 | Bus word loaded on the last read/write edge |
| field_copy | output | 32 | Shadow copy of the field register |
| addr_err | output | 1 | Illegal address used on the last read/write edge |

## Verification
The bound checker watches the following on every cycle:
- Outputs stay frozen across capture edges.
- A latched reject always turns into a write address of 130.
- `field_copy` moves only after an accepted write to 131.
- `bus_valid` and `addr_err` track the latched addresses.
- The zero alias on port A holds.

What the assertions cannot see is the actual storage contents: that a discarded, bus-routed, illegal or redirected write left every other location intact, and that reads within one edge return the prior contents. The bench shows these by comparing every read against a behavioural array model, over directed cases and random address mixes.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Kind of action the write port takes for a given latched address.
  typedef enum logic [1:0] {
    WK_STORE = 2'd0,
    WK_DROP  = 2'd1,
    WK_BUS   = 2'd2,
    WK_BAD   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/rf_addr_latch.sv
module rf_addr_latch #(
  parameter int AW    = 8,
  parameter int CW    = 32,
  parameter int A_LSB = 0,
  parameter int B_LSB = 8,
  parameter int C_LSB = 16,
  parameter logic [AW-1:0] JUNK_ADDR = 8'd128,
  parameter logic [AW-1:0] MAR_ADDR  = 8'd130,
  parameter logic [AW-1:0] ZERO_ADDR = 8'd132
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_b,
  input  logic [CW-1:0] ctrl_word,
  input  logic          reject_in,
  output logic [AW-1:0] a_q,
  output logic [AW-1:0] b_q,
  output logic [AW-1:0] c_q,
  output logic          rej_q
);
  logic [AW-1:0] a_fld, b_fld, c_fld;
  logic          unused_ctrl;

  assign a_fld = ctrl_word[A_LSB +: AW];
  assign b_fld = ctrl_word[B_LSB +: AW];
  assign c_fld = ctrl_word[C_LSB +: AW];
  assign unused_ctrl = ^ctrl_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= ZERO_ADDR;
      b_q   <= ZERO_ADDR;
      c_q   <= JUNK_ADDR;
      rej_q <= 1'b0;
    end else if (ph_b) begin
      a_q   <= a_fld;
      b_q   <= b_fld;
      // a rejected cycle saves its address in the memory address register
      c_q   <= reject_in ? MAR_ADDR : c_fld;
      rej_q <= reject_in;
    end
  end
endmodule

// File: rtl/rf_write_route.sv
module rf_write_route
  import rf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int DEPTH = 160,
  parameter logic [AW-1:0] JUNK_ADDR  = 8'd128,
  parameter logic [AW-1:0] BUS_ADDR   = 8'd129,
  parameter logic [AW-1:0] FIELD_ADDR = 8'd131
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_b,
  input  logic [AW-1:0] c_q,
  input  logic          rej_q,
  input  logic [DW-1:0] wr_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_wa,
  output logic [DW-1:0] mem_wd,
  output logic [DW-1:0] bus_out,
  output logic          bus_valid,
  output logic [DW-1:0] field_copy,
  output logic          wr_bad
);
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

  wr_kind_e kind;
  logic     act;

  assign act = !ph_b;

  always_comb begin
    if (c_q >= LIMIT)           kind = WK_BAD;
    else if (c_q == JUNK_ADDR)  kind = WK_DROP;
    else if (c_q == BUS_ADDR)   kind = WK_BUS;
    else                        kind = WK_STORE;
  end

  assign mem_we = act && (kind == WK_STORE);
  assign mem_wa = c_q;
  assign mem_wd = wr_data;
  assign wr_bad = (kind == WK_BAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out   <= '0;
      bus_valid <= 1'b0;
    end else if (act) begin
      bus_valid <= (kind == WK_BUS);
      if (kind == WK_BUS) bus_out <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      field_copy <= '0;
    else if (act && !rej_q && c_q == FIELD_ADDR)
      field_copy <= wr_data;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int DEPTH = 160,
  parameter int NRD   = 2,
  parameter logic [AW-1:0] JUNK_ADDR = 8'd128,
  parameter logic [AW-1:0] BUS_ADDR  = 8'd129,
  parameter logic [AW-1:0] ZERO_ADDR = 8'd132
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  input  logic                     we,
  input  logic [AW-1:0]            wa,
  input  logic [DW-1:0]            wd,
  output logic [NRD-1:0][DW-1:0]   rd_data,
  output logic [NRD-1:0]           rd_bad
);
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic          legal, blank, blank_q;
    logic [AW-1:0] idx;
    logic [DW-1:0] raw_q;

    assign legal = rd_addr[p] < LIMIT;
    assign blank = !legal || rd_addr[p] == ZERO_ADDR ||
                   rd_addr[p] == JUNK_ADDR || rd_addr[p] == BUS_ADDR;
    assign idx   = legal ? rd_addr[p] : '0;
    assign rd_bad[p] = !legal;

    // plain registered read (no reset) so the array maps onto block RAM
    always_ff @(posedge clk) begin
      if (rd_en) raw_q <= mem[idx];
    end

    always_ff @(posedge clk) begin
      if (rst)        blank_q <= 1'b1;
      else if (rd_en) blank_q <= blank;
    end

    assign rd_data[p] = blank_q ? '0 : raw_q;
  end
endmodule

// File: rtl/rf_special.sv
module rf_special #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int CW    = 32,
  parameter int DEPTH = 160,
  parameter int A_LSB = 0,
  parameter int B_LSB = 8,
  parameter int C_LSB = 16,
  parameter logic [AW-1:0] JUNK_ADDR  = 8'd128,
  parameter logic [AW-1:0] BUS_ADDR   = 8'd129,
  parameter logic [AW-1:0] MAR_ADDR   = 8'd130,
  parameter logic [AW-1:0] FIELD_ADDR = 8'd131,
  parameter logic [AW-1:0] ZERO_ADDR  = 8'd132
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_b,
  input  logic [CW-1:0] ctrl_word,
  input  logic          reject_in,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] bus_out,
  output logic          bus_valid,
  output logic [DW-1:0] field_copy,
  output logic          addr_err
);
  localparam int NRD = 2;

  logic [AW-1:0]          a_q, b_q, c_q;
  logic                   rej_q;
  logic                   mem_we, wr_bad;
  logic [AW-1:0]          mem_wa;
  logic [DW-1:0]          mem_wd;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_data;
  logic [NRD-1:0]         rd_bad;

  rf_addr_latch #(
    .AW(AW), .CW(CW), .A_LSB(A_LSB), .B_LSB(B_LSB), .C_LSB(C_LSB),
    .JUNK_ADDR(JUNK_ADDR), .MAR_ADDR(MAR_ADDR), .ZERO_ADDR(ZERO_ADDR)
  ) u_latch (
    .clk(clk), .rst(rst), .ph_b(ph_b), .ctrl_word(ctrl_word),
    .reject_in(reject_in), .a_q(a_q), .b_q(b_q), .c_q(c_q), .rej_q(rej_q)
  );

  rf_write_route #(
    .DW(DW), .AW(AW), .DEPTH(DEPTH), .JUNK_ADDR(JUNK_ADDR),
    .BUS_ADDR(BUS_ADDR), .FIELD_ADDR(FIELD_ADDR)
  ) u_route (
    .clk(clk), .rst(rst), .ph_b(ph_b), .c_q(c_q), .rej_q(rej_q),
    .wr_data(wr_data), .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd),
    .bus_out(bus_out), .bus_valid(bus_valid), .field_copy(field_copy),
    .wr_bad(wr_bad)
  );

  assign rd_addr[0] = a_q;
  assign rd_addr[1] = b_q;

  rf_storage #(
    .DW(DW), .AW(AW), .DEPTH(DEPTH), .NRD(NRD), .JUNK_ADDR(JUNK_ADDR),
    .BUS_ADDR(BUS_ADDR), .ZERO_ADDR(ZERO_ADDR)
  ) u_store (
    .clk(clk), .rst(rst), .rd_en(!ph_b), .rd_addr(rd_addr),
    .we(mem_we), .wa(mem_wa), .wd(mem_wd), .rd_data(rd_data), .rd_bad(rd_bad)
  );

  assign rd_a = rd_data[0];
  assign rd_b = rd_data[1];

  always_ff @(posedge clk) begin
    if (rst)        addr_err <= 1'b0;
    else if (!ph_b) addr_err <= wr_bad || (|rd_bad);
  end
endmodule

// File: rtl/rf_special_chk.sv
module rf_special_chk #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int DEPTH = 160,
  parameter logic [AW-1:0] BUS_ADDR   = 8'd129,
  parameter logic [AW-1:0] MAR_ADDR   = 8'd130,
  parameter logic [AW-1:0] FIELD_ADDR = 8'd131,
  parameter logic [AW-1:0] ZERO_ADDR  = 8'd132
) (
  input logic          clk,
  input logic          rst,
  input logic          ph_b,
  input logic          reject_in,
  input logic [AW-1:0] a_q,
  input logic [AW-1:0] b_q,
  input logic [AW-1:0] c_q,
  input logic          rej_q,
  input logic [DW-1:0] rd_a,
  input logic [DW-1:0] rd_b,
  input logic          bus_valid,
  input logic [DW-1:0] field_copy,
  input logic          addr_err
);
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_valid && !addr_err && field_copy == '0 && rd_a == '0));

  a_r2_hold_on_capture: assert property (@(posedge clk) disable iff (rst)
    ($past(ph_b) && !$past(rst)) |->
      ($stable(rd_a) && $stable(rd_b) && $stable(bus_valid) && $stable(addr_err)
       && $stable(field_copy)));

  a_r4_zero_alias: assert property (@(posedge clk) disable iff (rst)
    (!$past(ph_b) && !$past(rst) && $past(a_q) == ZERO_ADDR) |-> rd_a == '0);

  a_r6_bus_strobe: assert property (@(posedge clk) disable iff (rst)
    (!$past(ph_b) && !$past(rst)) |-> (bus_valid == ($past(c_q) == BUS_ADDR)));

  a_r7_reject_redirect: assert property (@(posedge clk) disable iff (rst)
    ($past(ph_b) && $past(reject_in) && !$past(rst)) |-> (c_q == MAR_ADDR && rej_q));

  a_r8_field_only_on_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !(!$past(ph_b) && !$past(rej_q) && $past(c_q) == FIELD_ADDR))
      |-> $stable(field_copy));

  a_r9_error_flag: assert property (@(posedge clk) disable iff (rst)
    (!$past(ph_b) && !$past(rst)) |->
      (addr_err == ($past(a_q) >= LIMIT || $past(b_q) >= LIMIT || $past(c_q) >= LIMIT)));
endmodule

bind rf_special rf_special_chk #(
  .DW(DW), .AW(AW), .DEPTH(DEPTH), .BUS_ADDR(BUS_ADDR), .MAR_ADDR(MAR_ADDR),
  .FIELD_ADDR(FIELD_ADDR), .ZERO_ADDR(ZERO_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .ph_b(ph_b), .reject_in(reject_in), .a_q(a_q),
  .b_q(b_q), .c_q(c_q), .rej_q(rej_q), .rd_a(rd_a), .rd_b(rd_b),
  .bus_valid(bus_valid), .field_copy(field_copy), .addr_err(addr_err)
);

// File: tb/tb_rf_special.sv
module tb_rf_special;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ph_b = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        reject_in = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a, rd_b, bus_out, field_copy;
  logic        bus_valid, addr_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] mem_m [160];
  logic [31:0] field_m = '0;
  logic [31:0] bus_m = '0;

  rf_special dut (
    .clk(clk), .rst(rst), .ph_b(ph_b), .ctrl_word(ctrl_word),
    .reject_in(reject_in), .wr_data(wr_data), .rd_a(rd_a), .rd_b(rd_b),
    .bus_out(bus_out), .bus_valid(bus_valid), .field_copy(field_copy),
    .addr_err(addr_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [7:0] adr);
    if (adr >= 8'd160 || adr == 8'd128 || adr == 8'd129 || adr == 8'd132)
      return 32'h0;
    return mem_m[adr];
  endfunction

  function automatic string rd_tag(input logic [7:0] adr);
    if (adr >= 8'd160) return "R9 illegal read";
    if (adr == 8'd132) return "R4 zero alias";
    if (adr == 8'd128) return "R5 sink read";
    if (adr == 8'd129) return "R6 bus addr read";
    return "R3/R10 stored read";
  endfunction

  // one capture edge followed by one read/write edge, then compare with model
  task automatic do_op(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input bit rej, input logic [31:0] d);
    logic [31:0] pa, pb, pf;
    logic [7:0]  ce;
    logic        pv, pe;
    @(negedge clk);
    ph_b = 1'b1;
    ctrl_word = {8'($urandom), c, b, a};
    reject_in = rej;
    pa = rd_a; pb = rd_b; pf = field_copy; pv = bus_valid; pe = addr_err;
    @(posedge clk); #1;
    chk("R2 rd_a held over capture edge", rd_a, pa);
    chk("R2 rd_b held over capture edge", rd_b, pb);
    chk("R2 flags held over capture edge", {30'd0, bus_valid, addr_err}, {30'd0, pv, pe});
    chk("R2 field held over capture edge", field_copy, pf);
    @(negedge clk);
    ph_b = 1'b0;
    wr_data = d;
    reject_in = 1'($urandom);      // ignored on this edge
    ctrl_word = $urandom;          // ignored on this edge
    @(posedge clk); #1;
    ce = rej ? 8'd130 : c;
    chk(rd_tag(a), rd_a, rd_model(a));
    chk(rd_tag(b), rd_b, rd_model(b));
    chk("R9 addr_err", {31'd0, addr_err},
        {31'd0, (a >= 8'd160) || (b >= 8'd160) || (ce >= 8'd160)});
    chk("R6 bus_valid", {31'd0, bus_valid}, {31'd0, ce == 8'd129});
    if (ce == 8'd129) bus_m = d;
    chk("R6 bus_out", bus_out, bus_m);
    if (!rej && ce == 8'd131) field_m = d;
    chk(rej ? "R7 field untouched on reject" : "R8 field copy", field_copy, field_m);
    if (ce < 8'd128 || (ce >= 8'd130 && ce < 8'd160)) mem_m[ce] = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 rd_a after reset", rd_a, 32'h0);
    chk("R1 rd_b after reset", rd_b, 32'h0);
    chk("R1 bus_out after reset", bus_out, 32'h0);
    chk("R1 flags after reset", {30'd0, bus_valid, addr_err}, 32'h0);
    chk("R1 field after reset", field_copy, 32'h0);
    // a read/write edge before any capture: sink write, zero-alias reads
    wr_data = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    chk("R1 no bus strobe from reset write address", {31'd0, bus_valid}, 32'h0);
    chk("R1 reset read address reads zero", rd_a, 32'h0);
    chk("R1 field still clear", field_copy, 32'h0);

    // fill every location
    for (int i = 0; i < 160; i++)
      do_op(8'(i), 8'((i + 1) % 160), 8'(i), 1'b0, 32'hA500_0000 | 32'(i * 7));

    // R3 read-before-write on the same edge
    do_op(8'd5, 8'd5, 8'd5, 1'b0, 32'h1111_2222);
    do_op(8'd5, 8'd6, 8'd128, 1'b0, 32'h0);
    chk("R3 new value visible afterwards", rd_a, 32'h1111_2222);
    // R4 zero alias on both ports
    do_op(8'd132, 8'd132, 8'd132, 1'b0, 32'hFFFF_FFFF);
    do_op(8'd132, 8'd133, 8'd128, 1'b0, 32'h0);
    chk("R4 zero alias after write", rd_a, 32'h0);
    // R5 sink write leaves neighbours intact
    do_op(8'd127, 8'd130, 8'd128, 1'b0, 32'hBAD0_BAD0);
    do_op(8'd127, 8'd128, 8'd128, 1'b0, 32'h0);
    chk("R5 neighbour 127 unchanged", rd_a, mem_m[127]);
    chk("R5 sink reads zero", rd_b, 32'h0);
    // R6 bus route
    do_op(8'd0, 8'd1, 8'd129, 1'b0, 32'hC0FF_EE00);
    chk("R6 bus carries word", bus_out, 32'hC0FF_EE00);
    // R7 reject redirect with write field aimed at field register
    do_op(8'd0, 8'd1, 8'd131, 1'b1, 32'h7777_0001);
    do_op(8'd130, 8'd131, 8'd128, 1'b0, 32'h0);
    chk("R7 word landed in 130", rd_a, 32'h7777_0001);
    chk("R7 field register not written", rd_b, mem_m[131]);
    // R8 accepted field write
    do_op(8'd0, 8'd0, 8'd131, 1'b0, 32'h0F0F_1234);
    chk("R8 field copy loaded", field_copy, 32'h0F0F_1234);
    // R9 illegal write and illegal reads
    do_op(8'd200, 8'd160, 8'd170, 1'b0, 32'h5555_5555);
    do_op(8'd159, 8'd158, 8'd255, 1'b0, 32'h6666_6666);
    // R10 equal addresses on both ports
    do_op(8'd42, 8'd42, 8'd128, 1'b0, 32'h0);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] ra, rb, rc;
      ra = 8'($urandom_range(0, 175));
      rb = 8'($urandom_range(0, 175));
      rc = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(128, 132))
                                       : 8'($urandom_range(0, 175));
      do_op(ra, rb, rc, ($urandom_range(0, 7) == 0), $urandom);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule